// File: doc/BRIEF.md
# Round-Robin Multi-Line Sample Distributor

This block takes one stream of 32-bit words read from memory and deals them out to several serial audio data lines. Each line has its own FIFO, and every line runs from one shared bit and word clock. Each FIFO entry is one stereo frame: a left and a right 32-bit slot. The block visits only the lines set in an enable mask, in ascending index order. It skips lines that are switched off and wraps back to the lowest enabled line after the highest one. Each line it visits receives exactly one stereo frame.

Two packing modes are supported. In wide mode, two consecutive input words become the left and the right slot of one frame. In packed mode, one input word carries both channels as 16-bit halves. The lower half becomes the left channel and the upper half becomes the right channel. Each half is placed left-justified in its slot, with the low 16 bits zero-filled.

The block keeps a count of the frames held in each line's FIFO. It adds one for each frame it writes and subtracts one for each pop reported by that line's serializer. It stalls the input while the FIFO it is about to fill is full. It raises a refill request while any enabled FIFO is at or below a programmable low-water mark.

Top module: `rrline_distributor`

## Requirements
- R1: After reset, no FIFO write is pending, every frame count is zero, the pointer is at line 0, and `s_ready` is high when at least one line is enabled.
- R2: In wide mode (`pack_mode`=0), the first accepted word is held without a FIFO write. The next accepted word completes the frame as {left = first word, right = second word}. That frame is written in the cycle after the second word is accepted.
- R3: In packed mode (`pack_mode`=1), an accepted word W is written in the next cycle as one frame. The left slot is {W[15:0], 16'h0000} and the right slot is {W[31:16], 16'h0000}.
- R4: Frames go to enabled lines (`line_en[i]`=1) in ascending index order. Disabled lines are skipped. After the highest enabled line, the pointer wraps to the lowest enabled line.
- R5: Each line's frame count rises by one per frame written and falls by one per `fifo_pop[i]` pulse. A pop while the count is zero is ignored. A count never exceeds FIFO_DEPTH.
- R6: `s_ready` is low while the FIFO of the line to be filled holds FIFO_DEPTH frames. A stalled word is held by the sender and is delivered once space appears, so no word is lost.
- R7: `fill_req` is high exactly when some enabled line has a frame count less than or equal to `low_water`.
- R8: With no line enabled and no half frame held, `s_ready` is low.
- R9: At most one bit of `fifo_wr` is high in any cycle. It is high exactly in the cycle after a frame is completed.
- R10: While a left word is held in wide mode, the next accepted word always completes that frame on the line it was started for. Changes to `pack_mode` and `line_en` in the meantime do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_en | input | NUM_LINES | Mask of active data lines |
| pack_mode | input | 1 | 1: two 16-bit channels per word; 0: one 32-bit channel per word |
| low_water | input | LVL_W | Refill threshold in frames |
| s_valid | input | 1 | Input word valid |
| s_data | input | 32 | Input word |
| s_ready | output | 1 | Input word accepted when high together with `s_valid` |
| fifo_pop | input | NUM_LINES | One frame removed from a line's FIFO by its serializer |
| fifo_wr | output | NUM_LINES | Per-line FIFO write strobe |
| fifo_wdata_l | output | 32 | Left slot of the frame being written |
| fifo_wdata_r | output | 32 | Right slot of the frame being written |
| fill_req | output | 1 | Refill request to the memory reader |

## Verification
The assertions check on every cycle the properties that local state defines. These are: the write strobe is one-hot and follows a completed frame by exactly one cycle; no frame is committed to a full line; an empty mask stalls the input; the packed slot layout is correct; a held left word suppresses any write; and the frame counts stay within their bounds. Only the bench scenarios can show the sequence-level behaviour. That includes the ascending order with disabled lines skipped and the wrap back to the lowest line, as well as the frame order of a long stream under random pops. The bench scenarios also cover a stall on a full FIFO followed by delivery with no loss, a pop that is ignored at zero, and a frame that completes on its original line after the mask and mode change mid-frame.

// File: rtl/rrd_pkg.sv
package rrd_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  typedef struct packed {
    logic [WORD_W-1:0] left;
    logic [WORD_W-1:0] right;
  } frame_t;

  // packed word: low half is the left channel, high half the right one,
  // each left-justified in its 32-bit slot
  function automatic frame_t split_word(input logic [WORD_W-1:0] w);
    frame_t f;
    f.left  = {w[HALF_W-1:0], {(WORD_W-HALF_W){1'b0}}};
    f.right = {w[WORD_W-1:HALF_W], {(WORD_W-HALF_W){1'b0}}};
    return f;
  endfunction

  function automatic frame_t join_words(input logic [WORD_W-1:0] l,
                                        input logic [WORD_W-1:0] r);
    frame_t f;
    f.left  = l;
    f.right = r;
    return f;
  endfunction
endpackage

// File: rtl/rrd_rr_select.sv
module rrd_rr_select #(
  parameter int NUM_LINES = 4,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_en,
  input  logic                 advance,
  input  logic [IDX_W-1:0]     adv_from,
  output logic [IDX_W-1:0]     tgt_idx,
  output logic                 any_en
);
  logic [IDX_W-1:0] ptr_q;

  // first enabled line at or after the pointer, wrapping to the lowest
  function automatic logic [IDX_W-1:0] first_from(input logic [NUM_LINES-1:0] en,
                                                  input logic [IDX_W-1:0] ptr);
    logic [IDX_W-1:0] res;
    logic found;
    res = '0;
    found = 1'b0;
    for (int k = 0; k < NUM_LINES; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= NUM_LINES) idx = idx - NUM_LINES;
      if (!found && en[idx]) begin
        res = IDX_W'(idx);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] from);
    return (int'(from) == NUM_LINES - 1) ? '0 : from + 1'b1;
  endfunction

  assign tgt_idx = first_from(line_en, ptr_q);
  assign any_en  = |line_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (advance) ptr_q <= step_idx(adv_from);
  end
endmodule

// File: rtl/rrd_line_levels.sv
module rrd_line_levels #(
  parameter int NUM_LINES  = 4,
  parameter int FIFO_DEPTH = 8,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LINES-1:0]       commit_vec,
  input  logic [NUM_LINES-1:0]       pop_vec,
  input  logic [LVL_W-1:0]           low_water,
  output logic [NUM_LINES-1:0]       full_vec,
  output logic [NUM_LINES-1:0]       low_vec,
  output logic [NUM_LINES*LVL_W-1:0] level_flat
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [LVL_W-1:0] lvl_q;
    logic             pop_eff;

    assign pop_eff = pop_vec[i] && (lvl_q != '0);
    assign full_vec[i] = (lvl_q == LVL_W'(FIFO_DEPTH));
    assign low_vec[i]  = (lvl_q <= low_water);
    assign level_flat[i*LVL_W +: LVL_W] = lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_q + LVL_W'(commit_vec[i]) - LVL_W'(pop_eff);
    end
  end
endmodule

// File: rtl/rrd_pair_stage.sv
module rrd_pair_stage #(
  parameter int NUM_LINES = 4,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accept,
  input  logic                      pack_mode,
  input  logic [rrd_pkg::WORD_W-1:0] data,
  input  logic [IDX_W-1:0]          tgt_idx,
  output logic                      pending,
  output logic [IDX_W-1:0]          hold_idx,
  output logic                      commit_now,
  output rrd_pkg::frame_t           frame
);
  import rrd_pkg::*;

  logic [WORD_W-1:0] held_q;

  assign commit_now = accept && (pending || pack_mode);
  assign frame = pending ? join_words(held_q, data) : split_word(data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      held_q   <= '0;
      hold_idx <= '0;
    end else if (accept) begin
      if (pending) begin
        pending <= 1'b0;
      end else if (!pack_mode) begin
        pending  <= 1'b1;
        held_q   <= data;
        hold_idx <= tgt_idx;
      end
    end
  end
endmodule

// File: rtl/rrline_distributor.sv
module rrline_distributor #(
  parameter int NUM_LINES  = 4,
  parameter int FIFO_DEPTH = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_en,
  input  logic                 pack_mode,
  input  logic [LVL_W-1:0]     low_water,
  input  logic                 s_valid,
  input  logic [31:0]          s_data,
  output logic                 s_ready,
  input  logic [NUM_LINES-1:0] fifo_pop,
  output logic [NUM_LINES-1:0] fifo_wr,
  output logic [31:0]          fifo_wdata_l,
  output logic [31:0]          fifo_wdata_r,
  output logic                 fill_req
);
  import rrd_pkg::*;

  logic [IDX_W-1:0]           tgt_idx, hold_idx, cur_idx;
  logic                       any_en, pending, accept, commit_now;
  logic [NUM_LINES-1:0]       commit_vec, full_vec, low_vec;
  logic [NUM_LINES*LVL_W-1:0] level_flat;
  frame_t                     frame;

  rrd_rr_select #(.NUM_LINES(NUM_LINES)) sel_i (
    .clk(clk), .rst_n(rst_n), .line_en(line_en),
    .advance(commit_now), .adv_from(cur_idx),
    .tgt_idx(tgt_idx), .any_en(any_en)
  );

  rrd_pair_stage #(.NUM_LINES(NUM_LINES)) pair_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .pack_mode(pack_mode),
    .data(s_data), .tgt_idx(tgt_idx), .pending(pending),
    .hold_idx(hold_idx), .commit_now(commit_now), .frame(frame)
  );

  rrd_line_levels #(.NUM_LINES(NUM_LINES), .FIFO_DEPTH(FIFO_DEPTH)) lvl_i (
    .clk(clk), .rst_n(rst_n), .commit_vec(commit_vec), .pop_vec(fifo_pop),
    .low_water(low_water), .full_vec(full_vec), .low_vec(low_vec),
    .level_flat(level_flat)
  );

  assign cur_idx = pending ? hold_idx : tgt_idx;
  assign s_ready = (pending || any_en) && !full_vec[cur_idx];
  assign accept  = s_valid && s_ready;

  always_comb begin
    commit_vec = '0;
    commit_vec[cur_idx] = commit_now;
  end

  assign fill_req = |(low_vec & line_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_wr      <= '0;
      fifo_wdata_l <= '0;
      fifo_wdata_r <= '0;
    end else begin
      fifo_wr <= commit_vec;
      if (commit_now) begin
        fifo_wdata_l <= frame.left;
        fifo_wdata_r <= frame.right;
      end
    end
  end
endmodule

// File: rtl/rrd_checker.sv
module rrd_checker #(
  parameter int NUM_LINES  = 4,
  parameter int FIFO_DEPTH = 8,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_LINES-1:0]       line_en,
  input logic                       pack_mode,
  input logic                       s_valid,
  input logic [31:0]                s_data,
  input logic                       s_ready,
  input logic [NUM_LINES-1:0]       fifo_wr,
  input logic [31:0]                fifo_wdata_l,
  input logic [31:0]                fifo_wdata_r,
  input logic                       pending,
  input logic [NUM_LINES-1:0]       commit_vec,
  input logic [NUM_LINES-1:0]       full_vec,
  input logic [NUM_LINES*LVL_W-1:0] level_flat
);
  // R9
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fifo_wr));

  // R9
  wr_follows_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|commit_vec) |=> (fifo_wr == $past(commit_vec)));

  // R6
  no_full_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((commit_vec & full_vec) == '0));

  // R8
  idle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_en == '0 && !pending) |-> !s_ready);

  // R3
  packed_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && pack_mode && !pending) |=>
      (fifo_wdata_l == {$past(s_data[15:0]), 16'h0000} &&
       fifo_wdata_r == {$past(s_data[31:16]), 16'h0000}));

  // R2
  left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !pack_mode && !pending) |=> (pending && fifo_wr == '0));

  // R10
  right_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && pending) |=> (!pending && fifo_wdata_r == $past(s_data)));

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_lvl
    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level_flat[i*LVL_W +: LVL_W] <= LVL_W'(FIFO_DEPTH)));
  end
endmodule

bind rrline_distributor rrd_checker #(.NUM_LINES(NUM_LINES), .FIFO_DEPTH(FIFO_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .line_en(line_en), .pack_mode(pack_mode),
  .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .fifo_wr(fifo_wr),
  .fifo_wdata_l(fifo_wdata_l), .fifo_wdata_r(fifo_wdata_r), .pending(pending),
  .commit_vec(commit_vec), .full_vec(full_vec), .level_flat(level_flat)
);

// File: tb/rrline_distributor_tb_top.sv
`timescale 1ns/1ps
module rrline_distributor_tb_top;
  localparam int N = 4;
  localparam int D = 8;
  localparam int LW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [N-1:0]  line_en;
  logic          pack_mode;
  logic [LW-1:0] low_water;
  logic          s_valid;
  logic [31:0]   s_data;
  logic          s_ready;
  logic [N-1:0]  fifo_pop;
  logic [N-1:0]  fifo_wr;
  logic [31:0]   fifo_wdata_l, fifo_wdata_r;
  logic          fill_req;

  rrline_distributor #(.NUM_LINES(N), .FIFO_DEPTH(D)) dut_i (.*);

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural reference state
  int          mlvl[N];
  int          mptr;
  bit          mpend;
  logic [31:0] mheld;
  int          mhline;
  logic [N-1:0] mwr;
  logic [31:0] ml, mr;
  bit          last_acc;
  bit          rand_pop;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (mlvl[i]) mlvl[i] = 0;
    mptr = 0; mpend = 0; mheld = '0; mhline = 0;
    mwr = '0; ml = '0; mr = '0; last_acc = 0;
  endtask

  task automatic step();
    int tgt;
    bit rdy, fill;
    int commit_line;
    if (rand_pop) fifo_pop = N'($urandom);
    #1;
    tgt = -1;
    if (mpend) tgt = mhline;
    else begin
      for (int k = 0; k < N; k++) begin
        int idx = (mptr + k) % N;
        if (tgt < 0 && line_en[idx]) tgt = idx;
      end
    end
    rdy = (tgt >= 0) && (mlvl[tgt] != D);
    fill = 0;
    for (int i = 0; i < N; i++) if (line_en[i] && mlvl[i] <= int'(low_water)) fill = 1;
    check(s_ready === rdy, "R6 R8 s_ready", 64'(s_ready), 64'(rdy));
    check(fill_req === fill, "R7 fill_req", 64'(fill_req), 64'(fill));
    check(fifo_wr === mwr, "R4 R9 fifo_wr", 64'(fifo_wr), 64'(mwr));
    if (mwr != '0)
      check({fifo_wdata_l, fifo_wdata_r} === {ml, mr}, "R2 R3 frame data",
            {fifo_wdata_l, fifo_wdata_r}, {ml, mr});
    // next state
    last_acc = s_valid && rdy;
    commit_line = -1;
    if (last_acc) begin
      if (mpend) begin
        ml = mheld; mr = s_data; commit_line = mhline; mpend = 0;
      end else if (pack_mode) begin
        ml = {s_data[15:0], 16'h0}; mr = {s_data[31:16], 16'h0}; commit_line = tgt;
      end else begin
        mheld = s_data; mhline = tgt; mpend = 1;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (fifo_pop[i] && mlvl[i] > 0) mlvl[i]--;
      if (commit_line == i) mlvl[i]++;
    end
    mwr = '0;
    if (commit_line >= 0) begin
      mwr[commit_line] = 1'b1;
      mptr = (commit_line + 1) % N;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w);
    s_valid = 1'b1;
    s_data  = w;
    do step(); while (!last_acc);
    s_valid = 1'b0;
  endtask

  task automatic do_reset(input logic [N-1:0] en, input bit pk, input int lw);
    rand_pop = 0;
    fifo_pop = '0;
    s_valid = 0; s_data = '0;
    line_en = en; pack_mode = pk; low_water = LW'(lw);
    rst_n = 0;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(4'b1111, 0, 2);
    #1;
    check(s_ready === 1'b1, "R1 ready after reset", 64'(s_ready), 64'd1);
    check(fifo_wr === '0, "R1 no write after reset", 64'(fifo_wr), 64'd0);
    check(fill_req === 1'b1, "R1 fill_req after reset", 64'(fill_req), 64'd1);
    #1;
    // R2 wide mode pair
    do_reset(4'b0001, 0, 2);
    send(32'hAAAA_0001);
    #1; check(fifo_wr === '0, "R2 no write on left word", 64'(fifo_wr), 64'd0); #1;
    send(32'hBBBB_0002);
    #1;
    check(fifo_wr === 4'b0001 && fifo_wdata_l === 32'hAAAA_0001 && fifo_wdata_r === 32'hBBBB_0002,
          "R2 wide frame", {fifo_wdata_l, fifo_wdata_r}, 64'hAAAA0001_BBBB0002);
    #1;
    // R3 packed split
    do_reset(4'b0001, 1, 2);
    send(32'h1234_ABCD);
    #1;
    check({fifo_wdata_l, fifo_wdata_r} === 64'hABCD0000_12340000, "R3 packed halves",
          {fifo_wdata_l, fifo_wdata_r}, 64'hABCD0000_12340000);
    #1;
    // R4 skip disabled lines and wrap
    do_reset(4'b1010, 1, 2);
    send(32'h1); #1; check(fifo_wr === 4'b0010, "R4 first enabled", 64'(fifo_wr), 64'h2); #1;
    send(32'h2); #1; check(fifo_wr === 4'b1000, "R4 skip line 2", 64'(fifo_wr), 64'h8); #1;
    send(32'h3); #1; check(fifo_wr === 4'b0010, "R4 wrap to lowest", 64'(fifo_wr), 64'h2); #1;
    // R7 threshold
    do_reset(4'b0011, 1, 0);
    send(32'h5);
    #1; check(fill_req === 1'b1, "R7 one line still low", 64'(fill_req), 64'd1); #1;
    send(32'h6);
    step();
    #1; check(fill_req === 1'b0, "R7 all lines above mark", 64'(fill_req), 64'd0); #1;
    // R5 pop at zero ignored
    do_reset(4'b0001, 1, 0);
    fifo_pop = 4'b0001; step(); fifo_pop = '0;
    send(32'h7);
    step();
    #1; check(fill_req === 1'b0, "R5 pop at zero ignored", 64'(fill_req), 64'd0); #1;
    // R6 stall on full, no loss
    do_reset(4'b0001, 0, 0);
    for (int i = 0; i < 2 * D; i++) send(32'h100 + 32'(i));
    s_valid = 1; s_data = 32'hCAFE_0001;
    #1; check(s_ready === 1'b0, "R6 stall when full", 64'(s_ready), 64'd0); #1;
    step();
    fifo_pop = 4'b0001; step(); fifo_pop = '0;
    send(32'hCAFE_0001);
    send(32'hCAFE_0002);
    #1;
    check(fifo_wr === 4'b0001 && fifo_wdata_l === 32'hCAFE_0001 && fifo_wdata_r === 32'hCAFE_0002,
          "R6 stalled word delivered", {fifo_wdata_l, fifo_wdata_r}, 64'hCAFE0001_CAFE0002);
    #1;
    // R8 empty mask
    do_reset(4'b0000, 0, 0);
    s_valid = 1;
    #1; check(s_ready === 1'b0, "R8 no line enabled", 64'(s_ready), 64'd0); #1;
    step(); step();
    s_valid = 0;
    // R10 mid-frame mask and mode change
    do_reset(4'b0011, 0, 2);
    send(32'hDEAD_0001);
    line_en = 4'b0100; pack_mode = 1;
    send(32'hBEEF_0002);
    #1;
    check(fifo_wr === 4'b0001 && fifo_wdata_l === 32'hDEAD_0001 && fifo_wdata_r === 32'hBEEF_0002,
          "R10 frame closes on held line", {fifo_wdata_l, fifo_wdata_r}, 64'hDEAD0001_BEEF0002);
    #1;
    step(); step();
    // long streams against the model with random pops (R4 R9)
    do_reset(4'b1111, 0, 3);
    rand_pop = 1;
    for (int i = 0; i < 60; i++) send($urandom);
    line_en = 4'b0110; pack_mode = 1;
    for (int i = 0; i < 60; i++) send($urandom);
    line_en = 4'b1011; pack_mode = 0;
    for (int i = 0; i < 60; i++) send($urandom);
    rand_pop = 0; fifo_pop = '0;
    repeat (4) step();
    summary();
    $finish;
  end
endmodule